// File: doc/BRIEF.md
# Post-Event Interval Timer Bank

This block is a bank of independent interval timers for a wireless MAC. Some timers are armed by the end of a transmission and the others by the end of a reception. Each timer measures a programmable number of microseconds after its arming event and then raises a sticky done flag. The transmit controllers use that flag as a handshake: it tells them an acknowledgement timeout has expired, or that a short inter-frame gap has passed and a response may be sent.

Time advances only on cycles where a one-microsecond tick strobe is high. Each timer has its own 16-bit interval, its own enable and its own clear input. Timers with indices below `N_TX` are post-transmit timers. The remaining timers are post-receive timers. With the defaults there are two of each.

Top module: `evt_interval_bank`

## Requirements
- R1: After reset every `tmr_done` and `tmr_busy` bit is low.
- R2: A one-cycle `tx_end` pulse arms only the timers with index below `N_TX`. A one-cycle `rx_end` pulse arms only the timers with index `N_TX` and above.
- R3: A timer armed with interval L > 0 has `tmr_busy` high in the cycle after the arming pulse. It raises `tmr_done` and drops `tmr_busy` in the cycle after its L-th tick. Done and busy are never high together.
- R4: A running timer advances only on cycles where `us_tick` is high. Any number of cycles without a tick leaves it running and not done.
- R5: An arming event on a running timer restarts its count from zero. Ticks seen before the restart do not count toward the interval.
- R6: While a timer's `tmr_en` bit is low, arming events are ignored. Driving `tmr_en` low on a running timer cancels it: busy falls on the next cycle and done is not raised. A done flag that is already set is left as it is.
- R7: `tmr_done` stays high until that timer's `tmr_clr` bit is pulsed or the timer is armed again. A clear affects only its own timer. An arming event wins over a clear in the same cycle.
- R8: A timer armed with interval 0 raises `tmr_done`, with `tmr_busy` low, in the cycle after the arming pulse, without any tick.
- R9: Timers armed by the same event with different intervals finish independently, each after its own interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| tx_end | input | 1 | One-cycle pulse at the end of a transmission |
| rx_end | input | 1 | One-cycle pulse at the end of a reception |
| tmr_lim | input | N_TX+N_RX times 16 | Interval in microseconds per timer; timer i uses bits [16i+15:16i] |
| tmr_en | input | N_TX+N_RX | Per-timer enable |
| tmr_clr | input | N_TX+N_RX | Per-timer pulse that clears done |
| tmr_done | output | N_TX+N_RX | Per-timer sticky interval-elapsed flag |
| tmr_busy | output | N_TX+N_RX | Per-timer counting flag |

## Verification
A wrong internal count shows up at the ports as `tmr_done` rising on the wrong tick. Because the bench samples one cycle after each tick, an early or late count is caught on the exact tick where it happens. A fault in restart, cancel or the event routing appears as a busy or done vector that differs from the expected one, on the cycle after the arming pulse or the enable change. A done flag that is lost or cleared by mistake is seen during idle periods with ticks running, and when a neighbouring timer is cleared.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int TMR_W = 16;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             busy;
        logic             done;
    } tmr_state_t;

endpackage

// File: rtl/evt_arm_map.sv
module evt_arm_map #(
    parameter int N_TX = 2,
    parameter int N_RX = 2,
    localparam int N = N_TX + N_RX
) (
    input  logic         tx_end,
    input  logic         rx_end,
    output logic [N-1:0] arm
);

    for (genvar i = 0; i < N; i++) begin : g_map
        if (i < N_TX) begin : g_tx
            assign arm[i] = tx_end;
        end else begin : g_rx
            assign arm[i] = rx_end;
        end
    end

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic             en,
    input  logic             clr,
    input  logic [TMR_W-1:0] limit,
    output logic             done,
    output logic             busy
);

    tmr_state_t st_d, st_q;
    logic [TMR_W:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = {1'b0, st_q.cnt} + {{TMR_W{1'b0}}, 1'b1};
        if (clr) begin
            st_d.done = 1'b0;
        end
        if (!en) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (arm) begin
            st_d.cnt  = '0;
            st_d.busy = (limit != '0);
            st_d.done = (limit == '0);
        end else if (st_q.busy && tick) begin
            st_d.cnt = inc[TMR_W-1:0];
            if (inc >= {1'b0, limit}) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign busy = st_q.busy;

    p_no_dual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.done && st_q.busy));

    p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && en && !arm && !tick) |=> ($stable(st_q.cnt) && st_q.busy));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && en && limit != '0) |=> (st_q.busy && !st_q.done && st_q.cnt == '0));

    p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.busy);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clr && !(arm && en)) |=> st_q.done);

    p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && en && limit == '0) |=> (st_q.done && !st_q.busy));

endmodule

// File: rtl/evt_interval_bank.sv
module evt_interval_bank
    import evt_tmr_pkg::*;
#(
    parameter int N_TX = 2,
    parameter int N_RX = 2,
    localparam int N = N_TX + N_RX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             tx_end,
    input  logic             rx_end,
    input  logic [N*TMR_W-1:0] tmr_lim,
    input  logic [N-1:0]     tmr_en,
    input  logic [N-1:0]     tmr_clr,
    output logic [N-1:0]     tmr_done,
    output logic [N-1:0]     tmr_busy
);

    logic [N-1:0] arm;

    evt_arm_map #(.N_TX(N_TX), .N_RX(N_RX)) u_map (
        .tx_end (tx_end),
        .rx_end (rx_end),
        .arm    (arm)
    );

    for (genvar i = 0; i < N; i++) begin : g_chan
        evt_timer_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (us_tick),
            .arm   (arm[i]),
            .en    (tmr_en[i]),
            .clr   (tmr_clr[i]),
            .limit (tmr_lim[i*TMR_W +: TMR_W]),
            .done  (tmr_done[i]),
            .busy  (tmr_busy[i])
        );
    end

    p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && !rx_end && tmr_en == '1 && !tmr_busy[N-1] && !tmr_done[N-1])
            |=> (!tmr_busy[N-1] && !tmr_done[N-1]));

endmodule

// File: tb/sim_evt_interval_bank.sv
module sim_evt_interval_bank;

    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic          tx_end = 1'b0;
    logic          rx_end = 1'b0;
    logic [N*16-1:0] tmr_lim = '0;
    logic [N-1:0]  tmr_en = '0;
    logic [N-1:0]  tmr_clr = '0;
    logic [N-1:0]  tmr_done;
    logic [N-1:0]  tmr_busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    evt_interval_bank #(.N_TX(2), .N_RX(2)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .tx_end(tx_end),
        .rx_end(rx_end), .tmr_lim(tmr_lim), .tmr_en(tmr_en),
        .tmr_clr(tmr_clr), .tmr_done(tmr_done), .tmr_busy(tmr_busy)
    );

    typedef struct packed {
        logic        rx;
        logic [15:0] lim;
        logic [7:0]  ticks;
        logic [3:0]  done;
        logic [3:0]  busy;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b0, 16'd3, 8'd2, 4'b0000, 4'b0011},
        '{1'b0, 16'd3, 8'd3, 4'b0011, 4'b0000},
        '{1'b1, 16'd5, 8'd5, 4'b1100, 4'b0000},
        '{1'b1, 16'd5, 8'd4, 4'b0000, 4'b1100},
        '{1'b0, 16'd1, 8'd1, 4'b0011, 4'b0000},
        '{1'b1, 16'd0, 8'd0, 4'b1100, 4'b0000}
    };

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_lims(logic [15:0] v);
        for (int i = 0; i < N; i++) tmr_lim[i*16 +: 16] = v;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    task automatic fire(logic rx);
        @(negedge clk);
        if (rx) rx_end = 1'b1; else tx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        tx_end = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk);
        tmr_en  = '0;
        tmr_clr = '1;
        @(negedge clk);
        tmr_en  = '1;
        tmr_clr = '0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done", tmr_done, 4'b0000);
        check("R1 busy", tmr_busy, 4'b0000);
        rst_n = 1'b1;
        tmr_en = '1;

        // R2 R3 R8: table walk
        for (int k = 0; k < 6; k++) begin
            wipe();
            set_lims(TBL[k].lim);
            fire(TBL[k].rx);
            ticks(int'(TBL[k].ticks));
            check($sformatf("R2/R3 row %0d done", k), tmr_done, TBL[k].done);
            check($sformatf("R2/R3 row %0d busy", k), tmr_busy, TBL[k].busy);
        end

        // R4: no progress without ticks
        wipe();
        set_lims(16'd2);
        fire(1'b0);
        repeat (10) @(negedge clk);
        check("R4 idle busy", tmr_busy, 4'b0011);
        check("R4 idle done", tmr_done, 4'b0000);
        ticks(2);
        check("R4 after ticks", tmr_done, 4'b0011);

        // R7: done holds, clear only own timer, arm clears done
        repeat (5) ticks(1);
        check("R7 hold", tmr_done, 4'b0011);
        @(negedge clk) tmr_clr = 4'b0001;
        @(negedge clk) tmr_clr = 4'b0000;
        check("R7 clear own", tmr_done, 4'b0010);
        set_lims(16'd3);
        fire(1'b0);
        check("R7 arm clears done", tmr_done, 4'b0000);
        check("R7 arm busy", tmr_busy, 4'b0011);

        // R5: restart from zero
        wipe();
        set_lims(16'd4);
        fire(1'b0);
        ticks(3);
        fire(1'b0);
        ticks(3);
        check("R5 not yet", tmr_done, 4'b0000);
        check("R5 still busy", tmr_busy, 4'b0011);
        ticks(1);
        check("R5 done", tmr_done, 4'b0011);

        // R6: disabled timer ignores arm, cancel of running timer
        wipe();
        set_lims(16'd3);
        tmr_en = 4'b1110;
        fire(1'b0);
        check("R6 ignored arm", tmr_busy, 4'b0010);
        ticks(1);
        @(negedge clk) tmr_en = 4'b1100;
        @(negedge clk);
        check("R6 cancel busy", tmr_busy, 4'b0000);
        ticks(4);
        check("R6 cancel no done", tmr_done, 4'b0000);

        // R9: independent intervals
        wipe();
        tmr_lim[15:0]  = 16'd2;
        tmr_lim[31:16] = 16'd4;
        fire(1'b0);
        ticks(2);
        check("R9 first", tmr_done, 4'b0001);
        check("R9 first busy", tmr_busy, 4'b0010);
        ticks(2);
        check("R9 second", tmr_done, 4'b0011);

        // R7: arm wins over clear in the same cycle
        set_lims(16'd2);
        @(negedge clk);
        tx_end = 1'b1;
        tmr_clr = 4'b0011;
        @(negedge clk);
        tx_end = 1'b0;
        tmr_clr = 4'b0000;
        check("R7 arm over clear", tmr_busy, 4'b0011);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule